// File: doc/BRIEF.md
# Transmit Statistics Counter Bank

This block keeps two transmit statistics for an Ethernet MAC:
- a running total of the data and padding octets in frames that were sent successfully;
- a count of frames that were sent successfully after exactly one collision.

The MAC reports each completed frame on a small completion stream. A beat carries the octet count and a flag that marks a single-collision frame.

Software reads the counters through a simple 16-bit register port, and each read clears the counter it reads. The octet total is wider than one word, so it is read as a low word followed by a high word. A read of the low word takes a snapshot of the whole counter, so the two halves always belong to the same value.

Counting happens only while the statistics enable input is high. Either counter reaching the value 0xC0 sets a sticky interrupt flag, and software clears that flag by writing 1 to it. The completion stream never applies back-pressure: `fr_ready` is high in every cycle after reset, and any beat with `fr_valid` high is taken in that cycle.

Top module: `txstat_bank`

## Requirements
- R1: A taken completion beat (`fr_valid` high) while `stat_en` is 1 adds `fr_octets` to the 20-bit octet counter.
- R2: A taken completion beat while `stat_en` is 1 adds one to the 8-bit collision counter only when `fr_one_coll` is 1. Otherwise that counter is unchanged.
- R3: While `stat_en` is 0, completion beats leave both counters unchanged.
- R4: A read at byte address 0x6C returns octet counter bits 15..0 and clears the counter. A later read at 0x6E returns bits 19..16 of the value captured by that low read in data bits 3..0, with bits 15..4 zero.
- R5: A read at byte address 0x77 returns the collision counter in data bits 7..0, with bits 15..8 zero, and clears the counter.
- R6: Both counters wrap to zero past their maximum value, with no other effect.
- R7: When a clearing read and a counted beat fall in the same cycle, the counter becomes the beat's increment.
- R8: `upd_irq` is set in the cycle after an update that takes the octet counter from below 0xC0 to 0xC0 or more, or that takes the collision counter to 0xC0.
- R9: `upd_irq` stays set until a write to byte address 0x5E with data bit 0 equal to 1. A new event in the same cycle as that write keeps the flag set. A read at 0x5E returns the flag in bit 0.
- R10: After reset both counters are zero, `upd_irq` is 0, `rd_valid` is 0 and `rd_data` is 0.
- R11: `rd_valid` is high, with `rd_data` valid, in the cycle after each `rd_en`, and `fr_ready` is 1 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_valid | input | 1 | Frame completion beat present |
| fr_ready | output | 1 | Completion beat accepted (always 1 after reset) |
| fr_octets | input | 16 | Data plus padding octets of the frame |
| fr_one_coll | input | 1 | Frame saw exactly one collision |
| stat_en | input | 1 | Statistics counting enable |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data, one cycle after `rd_en` |
| rd_valid | output | 1 | `rd_data` is valid |
| upd_irq | output | 1 | Sticky update-statistics interrupt flag |

## Verification
The embedded assertions cover the following on every cycle:
- the counters hold when neither a count nor a clear is pending;
- a clearing read with no concurrent count leaves zero;
- the interrupt flag rises after a threshold event and does not drop without a clear;
- read data arrives one cycle after the strobe.

Only the bench's scenarios can show the rest:
- the exact octet sums;
- the split low/high word read of a value above 16 bits;
- wrap-around of both counters;
- the merge of a read-clear with a concurrent count;
- the case where a set and a clear land in the same cycle.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] A_OCT_LO = 8'h6C;
  localparam logic [ADDR_W-1:0] A_OCT_HI = 8'h6E;
  localparam logic [ADDR_W-1:0] A_COLL   = 8'h77;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h5E;
endpackage

// File: rtl/txstat_accum.sv
module txstat_accum #(
  parameter int CW = 8,
  parameter int IW = 1,
  parameter logic [CW-1:0] THR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic [IW-1:0] add_val,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  logic [CW:0] base_x, inc_x, sum_x;

  always_comb begin
    base_x = clr ? '0 : {1'b0, cnt};
    inc_x  = (CW+1)'(add_val);
    sum_x  = base_x + inc_x;
  end

  // threshold crossing, a carry out also passed through THR
  assign hit = add_en && (base_x[CW-1:0] < THR) &&
               (sum_x[CW] || (sum_x[CW-1:0] >= THR));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (add_en) cnt <= sum_x[CW-1:0];
    else if (clr)    cnt <= '0;
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !clr) |=> $stable(cnt));

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !add_en) |=> (cnt == '0));
endmodule

// File: rtl/txstat_irq.sv
module txstat_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b0;
    else if (set)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/txstat_regif.sv
module txstat_regif
  import txstat_pkg::*;
#(
  parameter int OCT_W  = 20,
  parameter int COLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OCT_W-1:0]  oct_cnt,
  input  logic [COLL_W-1:0] coll_cnt,
  input  logic              flag,
  output logic              oct_clr,
  output logic              coll_clr,
  output logic              irq_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int HI_W = OCT_W - DATA_W;

  logic [HI_W-1:0]   hi_hold;
  logic [DATA_W-1:0] rd_mux;

  assign oct_clr  = rd_en && (addr == A_OCT_LO);
  assign coll_clr = rd_en && (addr == A_COLL);
  assign irq_clr  = wr_en && (addr == A_STAT) && wr_data[0];

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_OCT_LO: rd_mux = oct_cnt[DATA_W-1:0];
      A_OCT_HI: rd_mux = DATA_W'(hi_hold);
      A_COLL:   rd_mux = DATA_W'(coll_cnt);
      A_STAT:   rd_mux = DATA_W'(flag);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_hold  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)   rd_data <= rd_mux;
      if (oct_clr) hi_hold <= oct_cnt[OCT_W-1:DATA_W];
    end
  end

  // R11
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R11
  rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/txstat_bank.sv
module txstat_bank
  import txstat_pkg::*;
#(
  parameter int OCT_W  = 20,
  parameter int COLL_W = 8,
  parameter int LEN_W  = 16,
  parameter int THRESH = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [LEN_W-1:0]  fr_octets,
  input  logic              fr_one_coll,
  input  logic              stat_en,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              upd_irq
);
  localparam logic [OCT_W-1:0]  OCT_THR  = OCT_W'(THRESH);
  localparam logic [COLL_W-1:0] COLL_THR = COLL_W'(THRESH);

  logic              take, oct_add, coll_add;
  logic              oct_clr, coll_clr, irq_clr;
  logic              oct_hit, coll_hit;
  logic [OCT_W-1:0]  oct_cnt;
  logic [COLL_W-1:0] coll_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) fr_ready <= 1'b0;
    else        fr_ready <= 1'b1;
  end

  assign take     = fr_valid && fr_ready;
  assign oct_add  = take && stat_en;
  assign coll_add = take && stat_en && fr_one_coll;

  txstat_accum #(.CW(OCT_W), .IW(LEN_W), .THR(OCT_THR)) oct_u (
    .clk(clk), .rst_n(rst_n), .add_en(oct_add), .add_val(fr_octets),
    .clr(oct_clr), .cnt(oct_cnt), .hit(oct_hit));

  txstat_accum #(.CW(COLL_W), .IW(1), .THR(COLL_THR)) coll_u (
    .clk(clk), .rst_n(rst_n), .add_en(coll_add), .add_val(1'b1),
    .clr(coll_clr), .cnt(coll_cnt), .hit(coll_hit));

  txstat_irq irq_u (
    .clk(clk), .rst_n(rst_n), .set(oct_hit || coll_hit),
    .clr(irq_clr), .flag(upd_irq));

  txstat_regif #(.OCT_W(OCT_W), .COLL_W(COLL_W)) reg_u (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .oct_cnt(oct_cnt), .coll_cnt(coll_cnt),
    .flag(upd_irq), .oct_clr(oct_clr), .coll_clr(coll_clr),
    .irq_clr(irq_clr), .rd_data(rd_data), .rd_valid(rd_valid));

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_en && !oct_clr && !coll_clr) |=> ($stable(oct_cnt) && $stable(coll_cnt)));

  // R2
  no_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fr_one_coll && !coll_clr) |=> $stable(coll_cnt));
endmodule

// File: tb/txstat_bank_tb_top.sv
module txstat_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fr_valid = 1'b0, fr_one_coll = 1'b0, stat_en = 1'b0;
  logic [15:0] fr_octets = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic        fr_ready, rd_valid, upd_irq;
  logic [15:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int unsigned oct_m = 0, coll_m = 0, hi_m = 0;
  bit flag_m = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  txstat_bank dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model updated alongside
  task automatic cyc(input bit fv, input int len, input bit oc, input bit re,
                     input bit we, input logic [7:0] a, input logic [15:0] wd,
                     input string tag);
    bit oclr = 0, cclr = 0, hit = 0;
    int unsigned ob, cb, osum;
    fr_valid = fv; fr_octets = 16'(len); fr_one_coll = oc;
    rd_en = re; wr_en = we; addr = a; wr_data = wd;
    if (re) begin
      case (a)
        8'h6C: begin exp_q.push_back(16'(oct_m)); hi_m = oct_m >> 16; oclr = 1; end
        8'h6E: exp_q.push_back(16'(hi_m));
        8'h77: begin exp_q.push_back(16'(coll_m)); cclr = 1; end
        8'h5E: exp_q.push_back(16'(flag_m));
        default: exp_q.push_back(16'h0);
      endcase
      tag_q.push_back(tag);
    end
    ob = oclr ? 0 : oct_m;
    cb = cclr ? 0 : coll_m;
    if (fv && stat_en) begin
      osum = ob + len;
      if (ob < 192 && osum >= 192) hit = 1;
      ob = osum & 32'hFFFFF;
      if (oc) begin
        if (cb + 1 == 192) hit = 1;
        cb = (cb + 1) & 32'hFF;
      end
    end
    oct_m = ob; coll_m = cb;
    if (hit) flag_m = 1;
    else if (we && a == 8'h5E && wd[0]) flag_m = 0;
    @(negedge clk);
    fr_valid = 0; rd_en = 0; wr_en = 0;
  endtask

  task automatic frame(input int len, input bit oc);
    cyc(1, len, oc, 0, 0, 8'h00, 16'h0, "R1");
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(0, 0, 0, 1, 0, a, 16'h0, tag);
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk);
    check(upd_irq === flag_m, tag, int'(upd_irq), int'(flag_m));
  endtask

  // monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (rst_n && rd_valid === 1'b1) begin
      if (exp_q.size() == 0) check(0, "R11 unexpected rd_valid", 1, 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, int'(rd_data), int'(e));
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data === 16'h0 && rd_valid === 1'b0, "R10 read port reset", int'(rd_data), 0);
    check(upd_irq === 1'b0, "R10 irq reset", int'(upd_irq), 0);
    rst_n = 1;
    @(negedge clk);
    check(fr_ready === 1'b1, "R11 fr_ready", int'(fr_ready), 1);
    rd(8'h6C, "R10 octet reset value");
    rd(8'h77, "R10 coll reset value");

    stat_en = 1;
    frame(64, 0); frame(60, 1); frame(40, 0);
    rd(8'h6C, "R1 octet sum");
    rd(8'h6E, "R4 high word small");
    rd(8'h77, "R2 coll only flagged");
    rd(8'h6C, "R4 cleared by read");
    rd(8'h77, "R5 cleared by read");

    stat_en = 0;
    frame(500, 1); frame(7, 1);
    stat_en = 1;
    rd(8'h6C, "R3 octet held");
    rd(8'h77, "R3 coll held");

    frame(16'hFFFF, 0); frame(16'h3346, 0);
    chk_irq("R8 octet crossing");
    rd(8'h6C, "R4 low word");
    rd(8'h6E, "R4 high word");
    rd(8'h5E, "R9 flag read");
    cyc(0, 0, 0, 0, 1, 8'h5E, 16'h1, "R9 clear");
    chk_irq("R9 w1c");

    for (int i = 0; i < 16; i++) frame(16'hFFFF, 0);
    frame(16, 0); frame(5, 0);
    rd(8'h6C, "R6 octet wrap");
    rd(8'h6E, "R6 octet wrap high");
    cyc(0, 0, 0, 0, 1, 8'h5E, 16'h1, "R9 clear");

    for (int i = 0; i < 191; i++) frame(1, 1);
    chk_irq("R8 coll below threshold");
    cyc(1, 1, 1, 0, 1, 8'h5E, 16'h1, "R9 set wins");
    chk_irq("R9 set wins over clear");
    for (int i = 0; i < 66; i++) frame(1, 1);
    rd(8'h77, "R6 coll wrap");

    frame(90, 1); frame(10, 1);
    cyc(1, 30, 1, 1, 0, 8'h6C, 16'h0, "R7 octet read with frame");
    rd(8'h6C, "R7 octet keeps increment");
    cyc(1, 30, 1, 1, 0, 8'h77, 16'h0, "R7 coll read with frame");
    rd(8'h77, "R7 coll keeps increment");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule